// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block takes one character at a time from a valid/ready handshake and sends it on a single serial output as an asynchronous frame. The frame is a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between frames. A restartable divider sets the bit period from the system clock. The divisor, the data-bit count, the parity mode and the stop-bit count are all inputs. They are captured when a character is accepted, so changing them while a frame is on the line does nothing until the next character.

The controller is a five-state machine:
- `ST_IDLE` moves to `ST_START` on a handshake.
- `ST_START` moves to `ST_DATA` on a bit tick.
- `ST_DATA` stays in place until the last active data bit ends. It then moves to `ST_PARITY` when parity is enabled and to `ST_STOP` otherwise.
- `ST_PARITY` moves to `ST_STOP` on a tick.
- `ST_STOP` may pass through a second stop bit. At the tick that ends its last stop bit it either returns to `ST_IDLE` or, when a new character is offered in that cycle, goes straight back to `ST_START`.

Top module: `sft_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1, `busy` is 0 and `in_ready` is 1.
- R2: The cycle after a handshake (`in_valid` and `in_ready` both 1 at a clock edge), `tx_line` goes to 0 for the start bit. Every bit of a frame lasts exactly `baud_div`+1 clock cycles, where `baud_div` is the divisor captured at that handshake.
- R3: The data bits follow the start bit, bit 0 of `in_data` first. The number of data bits is `cfg_bits`, with values below 5 treated as 5 and values above 9 treated as 9. `in_data` bits at or above that count never appear on the line.
- R4: `cfg_parity` encodes the parity mode as 00 for none, 01 for even, 10 for odd and 11 for none. When parity is enabled, one parity bit follows the data bits. Its value is the XOR of the active data bits, inverted for odd parity.
- R5: The frame ends with one high stop bit when `cfg_two_stop` is 0 and with two when it is 1.
- R6: `busy` is 1 for exactly the length of the frame, that is (1 + data bits + parity bits + stop bits) × (`baud_div`+1) cycles. An 8-bit, no-parity, one-stop frame therefore takes 10 bit times.
- R7: `in_ready` is 1 only when the block is idle or in the final cycle of the last stop bit, and is 0 at every other cycle of a frame.
- R8: Changing `baud_div`, `cfg_bits`, `cfg_parity`, `cfg_two_stop` or `in_data` after the handshake has no effect on the frame in progress.
- R9: A character offered during the final stop-bit cycle is accepted there. Its start bit follows the previous stop bit with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | DIV_W | Bit period in clocks minus one |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | The block can accept a character this cycle |
| in_data | input | 9 | Character; only the low `cfg_bits` bits are sent |
| cfg_bits | input | 4 | Data bits per character (clamped to 5..9) |
| cfg_parity | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| tx_line | output | 1 | Serial output, high when idle |
| busy | output | 1 | A frame is in progress |

## Verification
The main function is driven through a sweep that covers every data-bit count, every parity code, both stop lengths and divisors from 0 to 3. Comparing the line every cycle separates errors in bit order, bit count and per-bit timing. Characters with ones above the selected width show whether masking reaches the parity bit and the line. Out-of-range bit counts exercise the clamp. Two further patterns matter most:
- Changing every setting right after a handshake shows whether the format is really captured at the start of the frame.
- Holding `in_valid` high across two characters shows whether the second start bit follows the stop bit with no gap.

// File: rtl/sft_pkg.sv
`timescale 1ns/1ps
package sft_pkg;

    localparam int unsigned DATA_W   = 9;
    localparam int unsigned BITS_W   = 4;
    localparam logic [BITS_W-1:0] MIN_BITS = 4'd5;
    localparam logic [BITS_W-1:0] MAX_BITS = 4'd9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [BITS_W-1:0] nbits;
        logic              par_en;
        logic              two_stop;
    } frame_fmt_t;

endpackage

// File: rtl/sft_baud_gen.sv
`timescale 1ns/1ps
module sft_baud_gen #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == div);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sft_fmt_decode.sv
`timescale 1ns/1ps
module sft_fmt_decode
    import sft_pkg::*;
(
    input  logic [DATA_W-1:0] raw_data,
    input  logic [BITS_W-1:0] cfg_bits,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_two_stop,
    output frame_fmt_t        fmt,
    output logic [DATA_W-1:0] data_masked,
    output logic              par_bit
);
    logic [BITS_W-1:0] nbits;
    logic              odd_sel;

    always_comb begin
        if (cfg_bits < MIN_BITS) begin
            nbits = MIN_BITS;
        end else if (cfg_bits > MAX_BITS) begin
            nbits = MAX_BITS;
        end else begin
            nbits = cfg_bits;
        end
    end

    // Keep only the active data bits: they feed both the shifter and the parity.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign data_masked[g] = raw_data[g] & (nbits > BITS_W'(g));
    end

    assign odd_sel      = (cfg_parity == 2'b10);
    assign par_bit      = (^data_masked) ^ odd_sel;
    assign fmt.nbits    = nbits;
    assign fmt.par_en   = (cfg_parity == 2'b01) || (cfg_parity == 2'b10);
    assign fmt.two_stop = cfg_two_stop;
endmodule

// File: rtl/sft_tx.sv
`timescale 1ns/1ps
module sft_tx
    import sft_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [8:0]       in_data,
    input  logic [3:0]       cfg_bits,
    input  logic [1:0]       cfg_parity,
    input  logic             cfg_two_stop,
    output logic             tx_line,
    output logic             busy
);
    tx_state_e         state, state_d;
    frame_fmt_t        fmt_in, fmt_q;
    logic [DATA_W-1:0] data_in, shreg;
    logic              par_in, par_q;
    logic [DIV_W-1:0]  div_q;
    logic [BITS_W-1:0] bit_cnt;
    logic              stop_cnt;
    logic              baud_tick;
    logic              accept;
    logic              last_stop;
    logic              last_data;

    sft_fmt_decode u_decode (
        .raw_data     (in_data),
        .cfg_bits     (cfg_bits),
        .cfg_parity   (cfg_parity),
        .cfg_two_stop (cfg_two_stop),
        .fmt          (fmt_in),
        .data_masked  (data_in),
        .par_bit      (par_in)
    );

    sft_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .div     (div_q),
        .tick    (baud_tick)
    );

    assign last_stop = (state == ST_STOP) && (!fmt_q.two_stop || stop_cnt);
    assign last_data = (bit_cnt == fmt_q.nbits - 4'd1);
    assign in_ready  = (state == ST_IDLE) || (last_stop && baud_tick);
    assign accept    = in_valid && in_ready;

    // Next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:   if (accept) state_d = ST_START;
            ST_START:  if (baud_tick) state_d = ST_DATA;
            ST_DATA:   if (baud_tick && last_data)
                           state_d = fmt_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (baud_tick) state_d = ST_STOP;
            ST_STOP:   if (baud_tick && last_stop)
                           state_d = accept ? ST_START : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Frame datapath: format captured at the handshake, shifted on ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            fmt_q    <= '0;
            par_q    <= 1'b0;
            div_q    <= '0;
            bit_cnt  <= '0;
            stop_cnt <= 1'b0;
        end else if (accept) begin
            shreg    <= data_in;
            fmt_q    <= fmt_in;
            par_q    <= par_in;
            div_q    <= baud_div;
            bit_cnt  <= '0;
            stop_cnt <= 1'b0;
        end else if (baud_tick) begin
            if (state == ST_DATA) begin
                shreg   <= shreg >> 1;
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (state == ST_STOP) begin
                stop_cnt <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy = (state != ST_IDLE);
        unique case (state)
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = shreg[0];
            ST_PARITY: tx_line = par_q;
            default:   tx_line = 1'b1;
        endcase
    end
endmodule

// File: rtl/sft_tx_chk.sv
`timescale 1ns/1ps
module sft_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic tx_line,
    input logic busy,
    input logic tick
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    p_idle_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> in_ready);

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!tx_line && busy));

    p_hold_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> ($stable(tx_line) && busy));

    p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |-> !in_ready);
endmodule

bind sft_tx sft_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_line  (tx_line),
    .busy     (busy),
    .tick     (baud_tick)
);

// File: tb/sft_tx_tb.sv
`timescale 1ns/1ps
module sft_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] baud_div = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [8:0]       in_data = '0;
    logic [3:0]       cfg_bits = 4'd8;
    logic [1:0]       cfg_parity = 2'b00;
    logic             cfg_two_stop = 1'b0;
    logic             tx_line;
    logic             busy;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    bit    live    = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    sft_tx #(.DIV_W(DIV_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_div     (baud_div),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .cfg_bits     (cfg_bits),
        .cfg_parity   (cfg_parity),
        .cfg_two_stop (cfg_two_stop),
        .tx_line      (tx_line),
        .busy         (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic void check(string req, string what, logic got, logic want);
        n_tests++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, want, $time);
        end
    endfunction

    function automatic void check_int(string req, string what, int got, int want);
        n_tests++;
        if (got != want) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, want);
        end
    endfunction

    function automatic int clamp_bits(int b);
        if (b < 5) return 5;
        if (b > 9) return 9;
        return b;
    endfunction

    function automatic int frame_len(int b, int p, int two, int div);
        int par = (p == 1 || p == 2) ? 1 : 0;
        return (1 + clamp_bits(b) + par + 1 + two) * (div + 1);
    endfunction

    function automatic void push_bit(bit v, string t, int reps);
        for (int k = 0; k < reps; k++) begin
            exp_q.push_back(v);
            tag_q.push_back(t);
        end
    endfunction

    // Reference model: one queue entry per expected line cycle.
    function automatic void push_frame();
        int  reps = int'(baud_div) + 1;
        int  nb   = clamp_bits(int'(cfg_bits));
        bit  par  = 1'b0;
        push_bit(1'b0, "R2", reps);
        for (int i = 0; i < nb; i++) begin
            push_bit(in_data[i], "R3", reps);
            par ^= in_data[i];
        end
        if (cfg_parity == 2'b01) push_bit(par, "R4", reps);
        if (cfg_parity == 2'b10) push_bit(~par, "R4", reps);
        push_bit(1'b1, "R5", reps);
        if (cfg_two_stop) push_bit(1'b1, "R5", reps);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            tag_q.delete();
            live = 1'b0;
        end else begin
            bit acc;
            acc  = in_valid && (exp_q.size() <= 1);
            live = 1'b1;
            if (exp_q.size() > 0) begin
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
            if (acc) push_frame();
        end
    end

    always @(negedge clk) begin
        if (live && !done) begin
            bit    e_tx;
            string t;
            e_tx = (exp_q.size() > 0) ? exp_q[0] : 1'b1;
            t    = (exp_q.size() > 0) ? tag_q[0] : "R1";
            check(t, "tx_line", tx_line, e_tx);
            check("R6", "busy", busy, exp_q.size() > 0);
            check("R7", "in_ready", in_ready, exp_q.size() <= 1);
        end
    end

    task automatic send(input logic [8:0] d, input int b, input int p, input int two,
                        input int div, input bit scramble, output int seen);
        @(negedge clk);
        in_data      = d;
        cfg_bits     = 4'(b);
        cfg_parity   = 2'(p);
        cfg_two_stop = two[0];
        baud_div     = DIV_W'(div);
        in_valid     = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (scramble) begin
            in_data      = ~d;
            cfg_bits     = 4'd9;
            cfg_parity   = 2'b10;
            cfg_two_stop = 1'b1;
            baud_div     = DIV_W'(div + 3);
        end
        seen = 0;
        while (busy) begin
            seen++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL R6 watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset tx_line", tx_line, 1'b1);
        check("R1", "reset busy", busy, 1'b0);
        check("R1", "reset in_ready", in_ready, 1'b1);

        // R6: 8 bits, no parity, one stop = 10 bit times
        send(9'h0A5, 8, 0, 0, 3, 1'b0, seen);
        check_int("R6", "8N1 length", seen, 10 * 4);

        // R3 R4: 5 bits even, upper bits set and ignored
        send(9'h1F3, 5, 1, 1, 1, 1'b0, seen);
        check_int("R4", "5E2 length", seen, frame_len(5, 1, 1, 1));
        send(9'h155, 9, 2, 0, 2, 1'b0, seen);
        check_int("R4", "9O1 length", seen, frame_len(9, 2, 0, 2));
        send(9'h07E, 7, 1, 0, 0, 1'b0, seen);
        check_int("R2", "7E1 div0 length", seen, frame_len(7, 1, 0, 0));

        // R3 clamp, R4 code 11 = none
        send(9'h1C9, 2, 3, 0, 1, 1'b0, seen);
        check_int("R3", "clamp low length", seen, frame_len(5, 0, 0, 1));
        send(9'h1C9, 15, 0, 1, 1, 1'b0, seen);
        check_int("R3", "clamp high length", seen, frame_len(9, 0, 1, 1));

        // R8: everything changed right after the handshake
        send(9'h0B2, 6, 0, 0, 2, 1'b1, seen);
        check_int("R8", "captured format length", seen, frame_len(6, 0, 0, 2));

        // R9: two characters back to back
        begin
            realtime t1, t2;
            @(negedge clk);
            in_data = 9'h03C; cfg_bits = 4'd8; cfg_parity = 2'b01;
            cfg_two_stop = 1'b1; baud_div = DIV_W'(2); in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            t1 = $realtime;
            @(negedge clk);
            in_data = 9'h0C3;
            while (!in_ready) @(negedge clk);
            t2 = $realtime;
            @(negedge clk);
            in_valid = 1'b0;
            check_int("R9", "gap between handshakes", int'((t2 - t1) / CLK_PERIOD),
                      frame_len(8, 1, 1, 2));
            check("R9", "line busy after second handshake", busy, 1'b1);
            while (busy) @(negedge clk);
        end

        // Sweep of formats and divisors
        for (int i = 0; i < 20; i++) begin
            send(9'((i * 37 + 11) & 9'h1FF), 5 + (i % 5), i % 4, i % 2, i % 4, 1'b0, seen);
            check_int("R6", "sweep length", seen, frame_len(5 + (i % 5), i % 4, i % 2, i % 4));
        end

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule